// File: doc/BRIEF.md
# Serial Link Training Controller

This block tracks a serial link from power-up to normal traffic and through its exits. It walks the link through receiver search, training-sequence exchange and configuration into the active state. From there it can go to a retrain pass, to one of three power-saving states or to one of three special states: disabled, in-band reset and test loopback. Its only inputs are single-cycle event strobes raised by the rest of the PHY. It reports an encoded state, a link-up flag and a count of how many times the active link fell back into retraining.

The three training states each carry a cycle timeout, set by a parameter. A stalled exchange in the sequence or configuration stage drops the link back to receiver search. A receiver search that times out simply starts its window again. The two deeper power states leave in different ways. Light sleep wakes through a retrain pass. Deep sleep wakes by restarting the whole training from receiver search.

Top module: `lnk_trainer`

## Requirements
- R1: While `rstN` is low, `stateCode` reads Detect, `linkUp` is 0 and `retrainCnt` is 0.
- R2: Detect moves to Polling only on `rxDetected`. Polling moves to Configuration on `tsExchangeDone`. Configuration moves to Active on `trainOk`. Any other event in these states has no effect.
- R3: With no advancing event, Polling returns to Detect after `POLL_TMO` cycles and Configuration after `CFG_TMO` cycles, both counted from entry. Detect restarts its own `DETECT_TMO` window and stays in Detect.
- R4: In Active, `retrainReq` enters Recovery. In Recovery, `recovFail` enters Disabled and otherwise `recovDone` returns to Active. Failure wins when both are raised.
- R5: In Active, `aspmReq` enters Standby. In Standby only `idleExit` acts, and it returns to Active.
- R6: In Active, `pmReq` enters Light sleep. In Light sleep only `wakeEvt` acts, and it goes to Recovery.
- R7: In Active, `d3Req` enters Deep sleep. In Deep sleep only `wakeEvt` acts, and it goes to Detect.
- R8: In Disabled only `swEnable` acts, and it goes to Detect.
- R9: In Active, `hotResetReq` enters In-band reset, which moves to Detect on the next cycle. `loopbackReq` enters Loopback, which stays while `loopbackReq` is held and goes to Detect once it is low.
- R10: When several requests are raised together in Active, the order of precedence is hot reset, retrain, D3, PM, ASPM, loopback.
- R11: `linkUp` is 1 exactly when the state is Active or Standby.
- R12: `retrainCnt` increases by one on each Active-to-Recovery transition and on no other transition. It saturates at its all-ones value, 255 for the default width.
- R13: `stateCode` values are: Detect 0, Polling 1, Configuration 2, Active 3, Recovery 4, Standby 5, Light sleep 6, Deep sleep 7, Disabled 8, In-band reset 9, Loopback 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxDetected | input | 1 | Far-end receiver found |
| tsExchangeDone | input | 1 | Training-sequence exchange finished |
| trainOk | input | 1 | Configuration succeeded |
| retrainReq | input | 1 | Request to retrain the active link |
| recovDone | input | 1 | Recovery pass completed |
| recovFail | input | 1 | Recovery pass failed |
| aspmReq | input | 1 | Hardware standby entry request |
| idleExit | input | 1 | Electrical idle exit seen in standby |
| pmReq | input | 1 | Light-sleep entry request |
| d3Req | input | 1 | Deep-sleep entry request |
| wakeEvt | input | 1 | Wake from a sleep state |
| swEnable | input | 1 | Software re-enable of a disabled link |
| loopbackReq | input | 1 | Loopback request, held for the loopback duration |
| hotResetReq | input | 1 | In-band reset request |
| stateCode | output | 4 | Current state, encoded as in R13 |
| linkUp | output | 1 | Link usable for traffic |
| retrainCnt | output | CNT_W | Saturating count of retrain entries from Active |

## Verification
The bench targets the asymmetric exits. If light sleep woke straight into Active, or deep sleep woke into Recovery, the state stream would diverge at once. Timeout edges are sampled on the exact cycle of expiry, so an off-by-one limit shows up as a one-cycle early or late fall to Detect. All six Active requests are raised together and then in shrinking subsets to expose a wrong precedence. A run of more than 255 retrains, together with light-sleep wakes, catches a counter that wraps or that counts Recovery entries not made from Active.

// File: rtl/lnk_trainer_pkg.sv
package lnk_trainer_pkg;

  typedef enum logic [3:0] {
    ST_DETECT  = 4'd0,
    ST_POLL    = 4'd1,
    ST_CONFIG  = 4'd2,
    ST_ACTIVE  = 4'd3,
    ST_RECOV   = 4'd4,
    ST_STANDBY = 4'd5,
    ST_SLEEP   = 4'd6,
    ST_DEEP    = 4'd7,
    ST_OFF     = 4'd8,
    ST_HOTRST  = 4'd9,
    ST_LOOP    = 4'd10
  } linkState_t;

  typedef enum logic [1:0] {
    TMR_NONE   = 2'd0,
    TMR_DETECT = 2'd1,
    TMR_POLL   = 2'd2,
    TMR_CONFIG = 2'd3
  } tmrSel_t;

  typedef struct packed {
    logic    clrTimer;
    tmrSel_t tmrSel;
    logic    bumpRetrain;
  } ctrlStrobe_t;

  typedef struct packed {
    logic rxDetected;
    logic tsExchangeDone;
    logic trainOk;
    logic retrainReq;
    logic recovDone;
    logic recovFail;
    logic aspmReq;
    logic idleExit;
    logic pmReq;
    logic d3Req;
    logic wakeEvt;
    logic swEnable;
    logic loopbackReq;
    logic hotResetReq;
  } linkEvents_t;

endpackage

// File: rtl/lnk_trainer_dp.sv
module lnk_trainer_dp
  import lnk_trainer_pkg::*;
#(
  parameter int DETECT_TMO = 12000,
  parameter int POLL_TMO   = 24000,
  parameter int CFG_TMO    = 24000,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic             tmoHit,
  output logic [CNT_W-1:0] retrainCnt
);

  localparam int MAX_AB  = (DETECT_TMO > POLL_TMO) ? DETECT_TMO : POLL_TMO;
  localparam int MAX_TMO = (MAX_AB > CFG_TMO) ? MAX_AB : CFG_TMO;
  localparam int TMR_W   = $clog2(MAX_TMO + 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] limitM1;

  always_comb begin
    case (strobe.tmrSel)
      TMR_DETECT: limitM1 = TMR_W'(DETECT_TMO - 1);
      TMR_POLL:   limitM1 = TMR_W'(POLL_TMO - 1);
      TMR_CONFIG: limitM1 = TMR_W'(CFG_TMO - 1);
      default:    limitM1 = '1;
    endcase
  end

  assign tmoHit = (strobe.tmrSel != TMR_NONE) && (tmr == limitM1);

  // Stay-time counter, restarted by the control on every state change or expiry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmr <= '0;
    else if (strobe.clrTimer) tmr <= '0;
    else if (tmr != '1)       tmr <= tmr + TMR_W'(1);
  end

  // Retrain counter, held at all-ones once full.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          retrainCnt <= '0;
    else if (strobe.bumpRetrain && (retrainCnt != '1))  retrainCnt <= retrainCnt + CNT_W'(1);
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpRetrain && (retrainCnt == '1)) |=> (retrainCnt == '1)); // R12
  AST_CNT_ONLY_ON_BUMP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bumpRetrain |=> $stable(retrainCnt)); // R12

endmodule

// File: rtl/lnk_trainer_ctrl.sv
module lnk_trainer_ctrl
  import lnk_trainer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  linkEvents_t ev,
  input  logic        tmoHit,
  output ctrlStrobe_t strobe,
  output linkState_t  state,
  output logic        linkUp
);

  linkState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_DETECT:  if (ev.rxDetected) nextState = ST_POLL;
      ST_POLL: begin
        if (ev.tsExchangeDone) nextState = ST_CONFIG;
        else if (tmoHit)       nextState = ST_DETECT;
      end
      ST_CONFIG: begin
        if (ev.trainOk)        nextState = ST_ACTIVE;
        else if (tmoHit)       nextState = ST_DETECT;
      end
      ST_ACTIVE: begin
        if (ev.hotResetReq)      nextState = ST_HOTRST;
        else if (ev.retrainReq)  nextState = ST_RECOV;
        else if (ev.d3Req)       nextState = ST_DEEP;
        else if (ev.pmReq)       nextState = ST_SLEEP;
        else if (ev.aspmReq)     nextState = ST_STANDBY;
        else if (ev.loopbackReq) nextState = ST_LOOP;
      end
      ST_RECOV: begin
        if (ev.recovFail)      nextState = ST_OFF;
        else if (ev.recovDone) nextState = ST_ACTIVE;
      end
      ST_STANDBY: if (ev.idleExit)     nextState = ST_ACTIVE;
      ST_SLEEP:   if (ev.wakeEvt)      nextState = ST_RECOV;
      ST_DEEP:    if (ev.wakeEvt)      nextState = ST_DETECT;
      ST_OFF:     if (ev.swEnable)     nextState = ST_DETECT;
      ST_HOTRST:                       nextState = ST_DETECT;
      ST_LOOP:    if (!ev.loopbackReq) nextState = ST_DETECT;
      default:                         nextState = ST_DETECT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DETECT;
    else       state <= nextState;
  end

  always_comb begin
    case (state)
      ST_DETECT: strobe.tmrSel = TMR_DETECT;
      ST_POLL:   strobe.tmrSel = TMR_POLL;
      ST_CONFIG: strobe.tmrSel = TMR_CONFIG;
      default:   strobe.tmrSel = TMR_NONE;
    endcase
    strobe.clrTimer    = (nextState != state) || tmoHit;
    strobe.bumpRetrain = (state == ST_ACTIVE) && (nextState == ST_RECOV);
  end

  assign linkUp = (state == ST_ACTIVE) || (state == ST_STANDBY);

  AST_DETECT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DETECT && !ev.rxDetected) |=> (state == ST_DETECT)); // R2
  AST_POLL_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL && tmoHit && !ev.tsExchangeDone) |=> (state == ST_DETECT)); // R3
  AST_RECOV_FAIL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOV && ev.recovFail) |=> (state == ST_OFF)); // R4
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && ev.wakeEvt) |=> (state == ST_RECOV)); // R6
  AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP && ev.wakeEvt) |=> (state == ST_DETECT)); // R7
  AST_HOTRST_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOTRST) |=> (state == ST_DETECT)); // R9
  AST_HOTRST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && ev.hotResetReq) |=> (state == ST_HOTRST)); // R10
  AST_BUMP_INTO_RECOV: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpRetrain |=> (state == ST_RECOV)); // R12

endmodule

// File: rtl/lnk_trainer.sv
module lnk_trainer
  import lnk_trainer_pkg::*;
#(
  parameter int DETECT_TMO = 12000,
  parameter int POLL_TMO   = 24000,
  parameter int CFG_TMO    = 24000,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxDetected,
  input  logic             tsExchangeDone,
  input  logic             trainOk,
  input  logic             retrainReq,
  input  logic             recovDone,
  input  logic             recovFail,
  input  logic             aspmReq,
  input  logic             idleExit,
  input  logic             pmReq,
  input  logic             d3Req,
  input  logic             wakeEvt,
  input  logic             swEnable,
  input  logic             loopbackReq,
  input  logic             hotResetReq,
  output logic [3:0]       stateCode,
  output logic             linkUp,
  output logic [CNT_W-1:0] retrainCnt
);

  linkEvents_t ev;
  ctrlStrobe_t strobe;
  linkState_t  state;
  logic        tmoHit;

  assign ev.rxDetected     = rxDetected;
  assign ev.tsExchangeDone = tsExchangeDone;
  assign ev.trainOk        = trainOk;
  assign ev.retrainReq     = retrainReq;
  assign ev.recovDone      = recovDone;
  assign ev.recovFail      = recovFail;
  assign ev.aspmReq        = aspmReq;
  assign ev.idleExit       = idleExit;
  assign ev.pmReq          = pmReq;
  assign ev.d3Req          = d3Req;
  assign ev.wakeEvt        = wakeEvt;
  assign ev.swEnable       = swEnable;
  assign ev.loopbackReq    = loopbackReq;
  assign ev.hotResetReq    = hotResetReq;

  lnk_trainer_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (ev),
    .tmoHit (tmoHit),
    .strobe (strobe),
    .state  (state),
    .linkUp (linkUp)
  );

  lnk_trainer_dp #(
    .DETECT_TMO (DETECT_TMO),
    .POLL_TMO   (POLL_TMO),
    .CFG_TMO    (CFG_TMO),
    .CNT_W      (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tmoHit     (tmoHit),
    .retrainCnt (retrainCnt)
  );

  assign stateCode = state;

endmodule

// File: tb/lnk_trainer_tb_top.sv
module lnk_trainer_tb_top;

  localparam int DT = 6;
  localparam int PT = 5;
  localparam int CT = 7;

  localparam int E_RX = 0, E_TS = 1, E_TOK = 2, E_RT = 3, E_RD = 4, E_RF = 5, E_ASPM = 6;
  localparam int E_IDLE = 7, E_PM = 8, E_D3 = 9, E_WAKE = 10, E_SW = 11, E_LB = 12, E_HR = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] ev = '0;
  logic [3:0]  stateCode;
  logic        linkUp;
  logic [7:0]  retrainCnt;

  int vecs = 0;
  int miss = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lnk_trainer #(.DETECT_TMO(DT), .POLL_TMO(PT), .CFG_TMO(CT), .CNT_W(8)) dut_i (
    .clk(clk), .rstN(rstN),
    .rxDetected(ev[E_RX]), .tsExchangeDone(ev[E_TS]), .trainOk(ev[E_TOK]),
    .retrainReq(ev[E_RT]), .recovDone(ev[E_RD]), .recovFail(ev[E_RF]),
    .aspmReq(ev[E_ASPM]), .idleExit(ev[E_IDLE]), .pmReq(ev[E_PM]), .d3Req(ev[E_D3]),
    .wakeEvt(ev[E_WAKE]), .swEnable(ev[E_SW]), .loopbackReq(ev[E_LB]),
    .hotResetReq(ev[E_HR]),
    .stateCode(stateCode), .linkUp(linkUp), .retrainCnt(retrainCnt)
  );

  // Behavioural reference model: states as integers, see R13 for codes.
  int mState = 0, mTmr = 0, mCnt = 0, mPrev = 0;
  bit mTmo = 0;
  int nx;
  bit ex;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mTmr <= 0; mCnt <= 0; mPrev <= 0; mTmo <= 0;
    end else begin
      nx = mState; ex = 0;
      case (mState)
        0: if (ev[E_RX]) nx = 1; else if (mTmr == DT - 1) ex = 1;
        1: if (ev[E_TS]) nx = 2; else if (mTmr == PT - 1) begin ex = 1; nx = 0; end
        2: if (ev[E_TOK]) nx = 3; else if (mTmr == CT - 1) begin ex = 1; nx = 0; end
        3: begin
          if (ev[E_HR]) nx = 9;
          else if (ev[E_RT]) nx = 4;
          else if (ev[E_D3]) nx = 7;
          else if (ev[E_PM]) nx = 6;
          else if (ev[E_ASPM]) nx = 5;
          else if (ev[E_LB]) nx = 10;
        end
        4: if (ev[E_RF]) nx = 8; else if (ev[E_RD]) nx = 3;
        5: if (ev[E_IDLE]) nx = 3;
        6: if (ev[E_WAKE]) nx = 4;
        7: if (ev[E_WAKE]) nx = 0;
        8: if (ev[E_SW]) nx = 0;
        9: nx = 0;
        default: if (!ev[E_LB]) nx = 0;
      endcase
      if (mState == 3 && nx == 4 && mCnt < 255) mCnt <= mCnt + 1;
      mTmr   <= (nx != mState || ex) ? 0 : mTmr + 1;
      mPrev  <= mState;
      mTmo   <= ex;
      mState <= nx;
    end
  end

  function automatic string tagFor(int p, bit t);
    if (t) return "R3";
    case (p)
      0, 1, 2: return "R2";
      3:       return "R10";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare();
    vecs++;
    if (stateCode !== mState[3:0]) begin
      miss++;
      $display("FAIL %s stateCode actual=%0d expected=%0d", tagFor(mPrev, mTmo), stateCode, mState);
    end
    if (linkUp !== (mState == 3 || mState == 5)) begin
      miss++;
      $display("FAIL R11 linkUp actual=%0b expected=%0b", linkUp, (mState == 3 || mState == 5));
    end
    if (retrainCnt !== mCnt[7:0]) begin
      miss++;
      $display("FAIL R12 retrainCnt actual=%0d expected=%0d", retrainCnt, mCnt);
    end
  endtask

  task automatic expectState(int code, string tag);
    vecs++;
    if (stateCode !== code[3:0]) begin
      miss++;
      $display("FAIL %s directed stateCode actual=%0d expected=%0d", tag, stateCode, code);
    end
  endtask

  task automatic expectCnt(int n, string tag);
    vecs++;
    if (retrainCnt !== n[7:0]) begin
      miss++;
      $display("FAIL %s directed retrainCnt actual=%0d expected=%0d", tag, retrainCnt, n);
    end
  endtask

  function automatic logic [13:0] bitOf(int i);
    return 14'(1) << i;
  endfunction

  task automatic step(logic [13:0] e);
    ev = e;
    @(negedge clk);
    compare();
    ev = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step('0);
  endtask

  task automatic bringUp();
    step(bitOf(E_RX)); step(bitOf(E_TS)); step(bitOf(E_TOK));
    expectState(3, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();
    expectState(0, "R1"); expectCnt(0, "R1");
    expectState(0, "R13");
    rstN = 1'b1;

    // R2: gating and forward path
    idle(3); expectState(0, "R2");
    step(bitOf(E_TS) | bitOf(E_TOK)); expectState(0, "R2");
    step(bitOf(E_RX)); expectState(1, "R2");
    step(bitOf(E_TOK)); expectState(1, "R2");
    step(bitOf(E_TS)); expectState(2, "R2");
    step(bitOf(E_TOK)); expectState(3, "R11");

    // R3: timeouts
    step(bitOf(E_HR)); step('0); expectState(0, "R9");
    step(bitOf(E_RX)); idle(PT - 1); expectState(1, "R3");
    step('0); expectState(0, "R3");
    step(bitOf(E_RX)); step(bitOf(E_TS)); idle(CT - 1); expectState(2, "R3");
    step('0); expectState(0, "R3");
    idle(DT * 3); expectState(0, "R3");

    // R4 / R8: recovery and disabled
    bringUp();
    step(bitOf(E_RT)); expectState(4, "R4"); expectCnt(1, "R12");
    step(bitOf(E_RD)); expectState(3, "R4");
    step(bitOf(E_RT)); step(bitOf(E_RF) | bitOf(E_RD)); expectState(8, "R4");
    step(bitOf(E_RX) | bitOf(E_TS) | bitOf(E_TOK) | bitOf(E_WAKE) | bitOf(E_IDLE));
    expectState(8, "R8");
    step(bitOf(E_SW)); expectState(0, "R8");

    // R5 / R6 / R7: power states
    bringUp();
    step(bitOf(E_ASPM)); expectState(5, "R5");
    step(bitOf(E_WAKE)); expectState(5, "R5");
    step(bitOf(E_IDLE)); expectState(3, "R5");
    step(bitOf(E_PM)); expectState(6, "R6");
    step(bitOf(E_IDLE)); expectState(6, "R6");
    step(bitOf(E_WAKE)); expectState(4, "R6"); expectCnt(2, "R12");
    step(bitOf(E_RD));
    step(bitOf(E_D3)); expectState(7, "R7");
    step(bitOf(E_WAKE)); expectState(0, "R7");

    // R9: loopback and in-band reset
    bringUp();
    step(bitOf(E_LB)); expectState(10, "R9");
    step(bitOf(E_LB)); expectState(10, "R9");
    step('0); expectState(0, "R9");
    bringUp();
    step(bitOf(E_HR)); expectState(9, "R9");
    step('0); expectState(0, "R9");

    // R10: precedence in Active
    bringUp();
    step(bitOf(E_HR) | bitOf(E_RT) | bitOf(E_D3) | bitOf(E_PM) | bitOf(E_ASPM) | bitOf(E_LB));
    expectState(9, "R10");
    step('0); bringUp();
    step(bitOf(E_RT) | bitOf(E_D3) | bitOf(E_PM) | bitOf(E_ASPM) | bitOf(E_LB));
    expectState(4, "R10");
    step(bitOf(E_RD));
    step(bitOf(E_D3) | bitOf(E_PM) | bitOf(E_ASPM) | bitOf(E_LB)); expectState(7, "R10");
    step(bitOf(E_WAKE)); bringUp();
    step(bitOf(E_PM) | bitOf(E_ASPM) | bitOf(E_LB)); expectState(6, "R10");
    step(bitOf(E_WAKE)); step(bitOf(E_RD));
    step(bitOf(E_ASPM) | bitOf(E_LB)); expectState(5, "R10");
    step(bitOf(E_IDLE)); expectState(3, "R10");

    // R12: saturation
    for (int i = 0; i < 260; i++) begin
      step(bitOf(E_RT)); step(bitOf(E_RD));
    end
    expectCnt(255, "R12");

    // Mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [13:0] e;
      for (int b = 0; b < 14; b++) e[b] = ($urandom_range(5) == 0);
      step(e);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

endmodule